// File: doc/BRIEF.md
# 8080-Style Parallel Display Bus Controller (8-bit)

This block is the host side of an 8080-type parallel display bus with an 8-bit data path. Each transfer runs as one bus cycle made of three phases: a setup phase, a strobe phase and a hold phase, followed by idle turnaround cycles. Writes and reads each have their own phase lengths, counted in clock cycles. Chip select, register select and the strobe lines each have a polarity bit, so the block can drive active-low or active-high panels.

Two sources feed the sequencer. A register port accepts 16-bit command or data words for either of two chip selects. A small DMA engine reads 16-bit words from a word-wide memory port, from a base address up to and including a ceiling address. In both cases, each word becomes exactly one bus cycle that carries only the word's low byte. A 16-bit pixel therefore takes two words, with the high byte sent first. A sticky done flag marks the end of a DMA run.

The memory port returns data in the cycle after a fetch request and holds it until the next request.

Top module: `dispbus_host`

## Requirements
- R1: During reset and just after it, `busy`, `busOe`, `memRdEn`, `readValid` and `dmaDone` are 0 and `hostReady` is 1. Every control line sits at its inactive level: with all polarity bits at 0, `cs0Line`, `cs1Line`, `rsLine`, `wrLine` and `rdLine` are all 1.
- R2: An accepted write cycle runs for `wSetup` cycles of setup, then `wStrobe`+1 cycles with the write strobe active, then `wHold` cycles of hold, then `turnAround` cycles with chip select inactive. A setup or hold value of 0 adds no cycle. `busy` is 1 for the whole sequence, turnaround included, and the phases start in the cycle after acceptance.
- R3: Only bits [7:0] of a word reach `busOut`, and the upper byte is dropped. `busOe` is 1 and the byte is held constant from the first setup cycle to the last hold cycle of a write. Outside that window `busOe` is 0 and `busOut` is 0.
- R4: The logical register select is 0 for a command word (`hostIsData`=0) and 1 for a data word. It stays constant from the start of setup to the end of hold and is logically 0 outside a cycle. Only the chip select named by `hostCs` (0 selects `cs0Line`, 1 selects `cs1Line`) is active, during setup, strobe and hold.
- R5: For each of `polCs0`, `polCs1`, `polRs` and `polStrobe`, the value 1 makes the line high when active and the value 0 makes it low when active. `polStrobe` applies to both `wrLine` and `rdLine`.
- R6: A read cycle uses `rSetup`, `rStrobe` and `rHold`, pulses `rdLine` instead of `wrLine`, and keeps `busOe` at 0. `busIn` is sampled at the last strobe cycle. In the next cycle `readValid` is 1 for exactly one cycle and `readData` holds `busIn` zero-extended to 16 bits.
- R7: `hostReady` is 1 only when no bus cycle or turnaround is in progress and no DMA run is active. A request is taken on the clock edge where `hostValid` and `hostReady` are both 1. A held request waits and is never lost.
- R8: A rising edge of `dmaEnable` starts a run that fetches the words at addresses `dmaBase` through `dmaCeiling` in increasing order, with at most one fetch outstanding. Each word becomes one data write (register select 1) to the chip select chosen by `dmaCs` (0 or 1).
- R9: `dmaDone` becomes 1 in the cycle after the last word's turnaround ends. It stays 1 until `doneClear` is seen. When setting and clearing fall on the same edge, setting wins.
- R10: When `dmaEnable` rises in the same cycle as a host request, the DMA run wins: `hostReady` is 0 in that cycle, and the host word is sent only after the run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wSetup | input | 4 | Write setup cycles |
| wStrobe | input | 4 | Write strobe length minus one |
| wHold | input | 4 | Write hold cycles |
| rSetup | input | 4 | Read setup cycles |
| rStrobe | input | 4 | Read strobe length minus one |
| rHold | input | 4 | Read hold cycles |
| turnAround | input | 4 | Idle cycles after each access |
| polRs | input | 1 | Register select polarity (1 = high for data) |
| polStrobe | input | 1 | Write and read strobe polarity (1 = active high) |
| polCs0 | input | 1 | Chip select 0 polarity (1 = active high) |
| polCs1 | input | 1 | Chip select 1 polarity (1 = active high) |
| hostValid | input | 1 | Host request valid |
| hostWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| hostIsData | input | 1 | 1 = data word, 0 = command word |
| hostCs | input | 1 | Target chip select |
| hostWdata | input | 16 | Host word; only the low byte is sent |
| hostReady | output | 1 | Host request can be taken |
| readData | output | 16 | Last read byte, zero-extended |
| readValid | output | 1 | One-cycle pulse when `readData` updates |
| dmaEnable | input | 1 | Rising edge starts a DMA run |
| dmaCs | input | 1 | Chip select for DMA words |
| dmaBase | input | 6 | First word address |
| dmaCeiling | input | 6 | Last word address |
| doneClear | input | 1 | Clears the done flag |
| dmaDone | output | 1 | Sticky end-of-run flag |
| memRdEn | output | 1 | Memory fetch request |
| memAddr | output | 6 | Memory fetch address |
| memRdata | input | 16 | Memory word, valid the cycle after a fetch |
| busy | output | 1 | Bus cycle or turnaround in progress |
| cs0Line | output | 1 | Chip select 0 pin |
| cs1Line | output | 1 | Chip select 1 pin |
| rsLine | output | 1 | Register select pin |
| wrLine | output | 1 | Write strobe pin |
| rdLine | output | 1 | Read strobe pin |
| busOut | output | 8 | Bus data driven out |
| busOe | output | 1 | Bus output enable |
| busIn | input | 8 | Bus data read in |

## Verification
Two events can fall on the same clock edge. The first pair is a host request and a DMA start. The bench raises `hostValid` and `dmaEnable` together, expects `hostReady` low in that cycle, and expects the host word on the bus only after the last DMA word. The second pair is setting and clearing the done flag. The bench holds `doneClear` high for a whole run and expects `dmaDone` to read 1 for exactly one cycle. A behavioural model predicts every output on every cycle, so a wrong winner in either collision shows up as a miscompare in that cycle.

// File: rtl/dispbus_pkg.sv
`timescale 1ns/1ps
package dispbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic takeHost;     // latch a host word for the next cycle
    logic takeDma;      // latch the buffered DMA byte
    logic grabWord;     // memory data is valid this cycle
    logic cycActive;    // setup, strobe or hold
    logic strobeOn;     // strobe phase
    logic captureRead;  // last strobe cycle of a read
  } dpCtl_t;

endpackage

// File: rtl/dispbus_ctrl.sv
`timescale 1ns/1ps
module dispbus_ctrl
  import dispbus_pkg::*;
#(
  parameter int TW = 4,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] wSetup,
  input  logic [TW-1:0] wStrobe,
  input  logic [TW-1:0] wHold,
  input  logic [TW-1:0] rSetup,
  input  logic [TW-1:0] rStrobe,
  input  logic [TW-1:0] rHold,
  input  logic [TW-1:0] turnAround,
  input  logic          hostValid,
  input  logic          hostWrite,
  output logic          hostReady,
  input  logic          dmaEnable,
  input  logic [AW-1:0] dmaBase,
  input  logic [AW-1:0] dmaCeiling,
  input  logic          doneClear,
  output logic          dmaDone,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  output logic          busy,
  output dpCtl_t        ctl
);

  localparam logic [TW-1:0] ONE  = TW'(1);
  localparam logic [TW-1:0] ZERO = '0;
  localparam logic [AW-1:0] AINC = AW'(1);

  phase_t        phase;
  logic [TW-1:0] cnt;
  logic          curWrite, curDma, curLast;
  logic          dmaRun, enPrev, haveWord, inFlight, fetchedAll, doneReg;
  logic [AW-1:0] addr;

  logic          idle, startDma, takeHost, launch, accept, fetchNow, useWrite, endNow;
  logic [TW-1:0] selSetup, selStrobe, strobeVal, holdVal;

  always_comb begin
    idle      = (phase == PH_IDLE);
    startDma  = dmaEnable && !enPrev && !dmaRun;
    hostReady = idle && !dmaRun && !startDma;
    takeHost  = hostValid && hostReady;
    launch    = dmaRun && haveWord && idle;
    accept    = takeHost || launch;
    useWrite  = launch || hostWrite;
    selSetup  = useWrite ? wSetup  : rSetup;
    selStrobe = useWrite ? wStrobe : rStrobe;
    strobeVal = curWrite ? wStrobe : rStrobe;
    holdVal   = curWrite ? wHold   : rHold;
    fetchNow  = dmaRun && !haveWord && !inFlight && !fetchedAll;
    endNow    = (cnt == ZERO) &&
                ((phase == PH_TURN) ||
                 (phase == PH_HOLD && turnAround == ZERO) ||
                 (phase == PH_STROBE && holdVal == ZERO && turnAround == ZERO));
  end

  // cycle sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      curWrite <= 1'b0;
      curDma   <= 1'b0;
      curLast  <= 1'b0;
    end else if (accept) begin
      curWrite <= useWrite;
      curDma   <= launch;
      curLast  <= launch && fetchedAll;
      if (selSetup != ZERO) begin
        phase <= PH_SETUP;
        cnt   <= selSetup - ONE;
      end else begin
        phase <= PH_STROBE;
        cnt   <= selStrobe;
      end
    end else if (phase != PH_IDLE) begin
      if (cnt != ZERO) begin
        cnt <= cnt - ONE;
      end else begin
        case (phase)
          PH_SETUP: begin
            phase <= PH_STROBE;
            cnt   <= strobeVal;
          end
          PH_STROBE: begin
            if (holdVal != ZERO) begin
              phase <= PH_HOLD;
              cnt   <= holdVal - ONE;
            end else if (turnAround != ZERO) begin
              phase <= PH_TURN;
              cnt   <= turnAround - ONE;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_HOLD: begin
            if (turnAround != ZERO) begin
              phase <= PH_TURN;
              cnt   <= turnAround - ONE;
            end else begin
              phase <= PH_IDLE;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // DMA fetch loop, one word buffered
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaRun     <= 1'b0;
      enPrev     <= 1'b0;
      haveWord   <= 1'b0;
      inFlight   <= 1'b0;
      fetchedAll <= 1'b0;
      addr       <= '0;
    end else begin
      enPrev <= dmaEnable;
      if (startDma) begin
        dmaRun     <= 1'b1;
        addr       <= dmaBase;
        fetchedAll <= 1'b0;
        haveWord   <= 1'b0;
        inFlight   <= 1'b0;
      end else begin
        if (fetchNow) begin
          inFlight <= 1'b1;
          if (addr == dmaCeiling) fetchedAll <= 1'b1;
          else                    addr       <= addr + AINC;
        end
        if (inFlight) begin
          inFlight <= 1'b0;
          haveWord <= 1'b1;
        end
        if (launch) haveWord <= 1'b0;
        if (endNow && curDma && curLast) dmaRun <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             doneReg <= 1'b0;
    else if (endNow && curDma && curLast)  doneReg <= 1'b1;
    else if (doneClear)                    doneReg <= 1'b0;
  end

  always_comb begin
    ctl.takeHost    = takeHost;
    ctl.takeDma     = launch;
    ctl.grabWord    = inFlight;
    ctl.cycActive   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ctl.strobeOn    = (phase == PH_STROBE);
    ctl.captureRead = (phase == PH_STROBE) && (cnt == ZERO) && !curWrite;
    busy            = !idle;
    memRdEn         = fetchNow;
    memAddr         = addr;
    dmaDone         = doneReg;
  end

  // R8
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone && !doneClear) |=> dmaDone);

  // R7
  take_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady) |=> busy);

endmodule

// File: rtl/dispbus_dp.sv
`timescale 1ns/1ps
module dispbus_dp
  import dispbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          hostWrite,
  input  logic          hostIsData,
  input  logic          hostCs,
  input  logic [DW-1:0] hostWdata,
  input  logic          dmaCs,
  input  logic [DW-1:0] memRdata,
  input  logic          polRs,
  input  logic          polStrobe,
  input  logic          polCs0,
  input  logic          polCs1,
  input  logic [BW-1:0] busIn,
  output logic [DW-1:0] readData,
  output logic          readValid,
  output logic          cs0Line,
  output logic          cs1Line,
  output logic          rsLine,
  output logic          wrLine,
  output logic          rdLine,
  output logic [BW-1:0] busOut,
  output logic          busOe
);

  localparam int PADW = DW - BW;

  logic [BW-1:0] txData, dmaByte;
  logic          txRs, txCs, txWrite;
  logic          unusedHi;

  // the upper byte of every word is dropped on the narrow bus
  generate
    if (PADW > 0) begin : g_drop
      assign unusedHi = ^{hostWdata[DW-1:BW], memRdata[DW-1:BW]};
    end else begin : g_full
      assign unusedHi = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData    <= '0;
      txRs      <= 1'b0;
      txCs      <= 1'b0;
      txWrite   <= 1'b0;
      dmaByte   <= '0;
      readData  <= '0;
      readValid <= 1'b0;
    end else begin
      readValid <= ctl.captureRead;
      if (ctl.captureRead) readData <= {{PADW{1'b0}}, busIn};
      if (ctl.grabWord)    dmaByte  <= memRdata[BW-1:0];
      if (ctl.takeHost) begin
        txData  <= hostWdata[BW-1:0];
        txRs    <= hostIsData;
        txCs    <= hostCs;
        txWrite <= hostWrite;
      end else if (ctl.takeDma) begin
        txData  <= dmaByte;
        txRs    <= 1'b1;
        txCs    <= dmaCs;
        txWrite <= 1'b1;
      end
    end
  end

  always_comb begin
    cs0Line = ((ctl.cycActive && !txCs) == polCs0);
    cs1Line = ((ctl.cycActive &&  txCs) == polCs1);
    rsLine  = ((ctl.cycActive &&  txRs) == polRs);
    wrLine  = ((ctl.strobeOn  &&  txWrite) == polStrobe);
    rdLine  = ((ctl.strobeOn  && !txWrite) == polStrobe);
    busOe   = ctl.cycActive && txWrite;
    busOut  = busOe ? txData : '0;
  end

  // R4
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cycActive && $past(ctl.cycActive)) |-> $stable({txRs, txCs, txWrite, txData}));

  // R6
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    readValid |=> !readValid);

endmodule

// File: rtl/dispbus_host.sv
`timescale 1ns/1ps
module dispbus_host
  import dispbus_pkg::*;
#(
  parameter int TW = 4,
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] wSetup,
  input  logic [TW-1:0] wStrobe,
  input  logic [TW-1:0] wHold,
  input  logic [TW-1:0] rSetup,
  input  logic [TW-1:0] rStrobe,
  input  logic [TW-1:0] rHold,
  input  logic [TW-1:0] turnAround,
  input  logic          polRs,
  input  logic          polStrobe,
  input  logic          polCs0,
  input  logic          polCs1,
  input  logic          hostValid,
  input  logic          hostWrite,
  input  logic          hostIsData,
  input  logic          hostCs,
  input  logic [DW-1:0] hostWdata,
  output logic          hostReady,
  output logic [DW-1:0] readData,
  output logic          readValid,
  input  logic          dmaEnable,
  input  logic          dmaCs,
  input  logic [AW-1:0] dmaBase,
  input  logic [AW-1:0] dmaCeiling,
  input  logic          doneClear,
  output logic          dmaDone,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memRdata,
  output logic          busy,
  output logic          cs0Line,
  output logic          cs1Line,
  output logic          rsLine,
  output logic          wrLine,
  output logic          rdLine,
  output logic [BW-1:0] busOut,
  output logic          busOe,
  input  logic [BW-1:0] busIn
);

  dpCtl_t ctl;

  dispbus_ctrl #(.TW(TW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wSetup(wSetup), .wStrobe(wStrobe), .wHold(wHold),
    .rSetup(rSetup), .rStrobe(rStrobe), .rHold(rHold),
    .turnAround(turnAround),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostReady(hostReady),
    .dmaEnable(dmaEnable), .dmaBase(dmaBase), .dmaCeiling(dmaCeiling),
    .doneClear(doneClear), .dmaDone(dmaDone),
    .memRdEn(memRdEn), .memAddr(memAddr),
    .busy(busy), .ctl(ctl)
  );

  dispbus_dp #(.DW(DW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hostWrite(hostWrite), .hostIsData(hostIsData), .hostCs(hostCs),
    .hostWdata(hostWdata), .dmaCs(dmaCs), .memRdata(memRdata),
    .polRs(polRs), .polStrobe(polStrobe), .polCs0(polCs0), .polCs1(polCs1),
    .busIn(busIn), .readData(readData), .readValid(readValid),
    .cs0Line(cs0Line), .cs1Line(cs1Line), .rsLine(rsLine),
    .wrLine(wrLine), .rdLine(rdLine), .busOut(busOut), .busOe(busOe)
  );

endmodule

// File: tb/test_dispbus_host.sv
`timescale 1ns/1ps
module test_dispbus_host;

  localparam int TW = 4, AW = 6, DW = 16, BW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN;
  logic [TW-1:0] wSetup, wStrobe, wHold, rSetup, rStrobe, rHold, turnAround;
  logic          polRs, polStrobe, polCs0, polCs1;
  logic          hostValid, hostWrite, hostIsData, hostCs;
  logic [DW-1:0] hostWdata;
  logic          hostReady;
  logic [DW-1:0] readData;
  logic          readValid;
  logic          dmaEnable, dmaCs, doneClear, dmaDone;
  logic [AW-1:0] dmaBase, dmaCeiling;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdata;
  logic          busy, cs0Line, cs1Line, rsLine, wrLine, rdLine, busOe;
  logic [BW-1:0] busOut, busIn;

  dispbus_host #(.TW(TW), .AW(AW), .DW(DW), .BW(BW)) i_dispbus_host (
    .clk(clk), .rstN(rstN),
    .wSetup(wSetup), .wStrobe(wStrobe), .wHold(wHold),
    .rSetup(rSetup), .rStrobe(rStrobe), .rHold(rHold), .turnAround(turnAround),
    .polRs(polRs), .polStrobe(polStrobe), .polCs0(polCs0), .polCs1(polCs1),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostIsData(hostIsData),
    .hostCs(hostCs), .hostWdata(hostWdata), .hostReady(hostReady),
    .readData(readData), .readValid(readValid),
    .dmaEnable(dmaEnable), .dmaCs(dmaCs), .dmaBase(dmaBase), .dmaCeiling(dmaCeiling),
    .doneClear(doneClear), .dmaDone(dmaDone),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdata(memRdata),
    .busy(busy), .cs0Line(cs0Line), .cs1Line(cs1Line), .rsLine(rsLine),
    .wrLine(wrLine), .rdLine(rdLine), .busOut(busOut), .busOe(busOe), .busIn(busIn)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit cmpOn   = 0;

  // word memory, answers in the cycle after a fetch
  logic [DW-1:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = DW'((i * 16'h0137) ^ 16'hA05A);
  always @(negedge clk) if (memRdEn) memRdata <= mem[memAddr];

  // ---------------- behavioural reference model ----------------
  int        phQ[$];        // 0 setup, 1 strobe, 2 hold, 3 turnaround
  bit        tW, tRs, tCs, tDma, tLast;
  logic [7:0] tD;
  bit        mRun, mInF, mHave, mAll, mDone, mEnPrev, hostTook, expRv;
  int        mAddr;
  logic [15:0] mWord, expRd;

  always @(posedge clk) begin
    if (!rstN) begin
      phQ.delete();
      tW = 0; tRs = 0; tCs = 0; tDma = 0; tLast = 0; tD = 0;
      mRun = 0; mInF = 0; mHave = 0; mAll = 0; mDone = 0; mEnPrev = 0;
      hostTook = 0; expRv = 0; mAddr = 0; mWord = 0; expRd = 0;
    end else begin
      bit idle, start, hAcc, launch, fetch, endNow, wr;
      int p, s, st, h;
      idle   = (phQ.size() == 0);
      start  = dmaEnable && !mEnPrev && !mRun;
      hAcc   = hostValid && idle && !mRun && !start;
      launch = mRun && mHave && idle;
      fetch  = mRun && !mHave && !mInF && !mAll;
      expRv  = 0;
      endNow = 0;
      if (!idle) begin
        p = phQ.pop_front();
        if (p == 1 && (phQ.size() == 0 || phQ[0] != 1) && !tW) begin
          expRv = 1;
          expRd = {8'h00, busIn};
        end
        endNow = (phQ.size() == 0);
      end
      if (endNow && tDma && tLast) begin
        mDone = 1;
        mRun  = 0;
      end else if (doneClear) mDone = 0;
      if (start) begin
        mRun = 1; mAddr = int'(dmaBase); mAll = 0; mHave = 0; mInF = 0;
      end else begin
        if (mInF) begin mInF = 0; mHave = 1; mWord = memRdata; end
        if (fetch) begin
          mInF = 1;
          if (mAddr == int'(dmaCeiling)) mAll = 1;
          else mAddr = (mAddr + 1) % 64;
        end
        if (launch) mHave = 0;
      end
      if (hAcc || launch) begin
        wr    = launch ? 1'b1 : hostWrite;
        tW    = wr;
        tRs   = launch ? 1'b1 : hostIsData;
        tCs   = launch ? dmaCs : hostCs;
        tD    = launch ? mWord[7:0] : hostWdata[7:0];
        tDma  = launch;
        tLast = launch && mAll;
        s  = int'(wr ? wSetup  : rSetup);
        st = int'(wr ? wStrobe : rStrobe);
        h  = int'(wr ? wHold   : rHold);
        for (int k = 0; k < s; k++)      phQ.push_back(0);
        for (int k = 0; k <= st; k++)    phQ.push_back(1);
        for (int k = 0; k < h; k++)      phQ.push_back(2);
        for (int k = 0; k < int'(turnAround); k++) phQ.push_back(3);
      end
      hostTook = hAcc;
      mEnPrev  = dmaEnable;
    end
  end

  task automatic chk(input string tag, input string name, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, name, got, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      int  p;
      bit  act, stb, oe, memEn;
      p     = (phQ.size() != 0) ? phQ[0] : -1;
      act   = (p >= 0 && p <= 2);
      stb   = (p == 1);
      oe    = act && tW;
      memEn = mRun && !mHave && !mInF && !mAll;
      chk("R2", "busy",    16'(busy),    16'(phQ.size() != 0));
      chk("R5", "cs0Line", 16'(cs0Line), 16'((act && !tCs) == polCs0));
      chk("R5", "cs1Line", 16'(cs1Line), 16'((act && tCs) == polCs1));
      chk("R4", "rsLine",  16'(rsLine),  16'((act && tRs) == polRs));
      chk("R2", "wrLine",  16'(wrLine),  16'((stb && tW) == polStrobe));
      chk("R6", "rdLine",  16'(rdLine),  16'((stb && !tW) == polStrobe));
      chk("R3", "busOe",   16'(busOe),   16'(oe));
      chk("R3", "busOut",  16'(busOut),  16'(oe ? tD : 8'h00));
      chk("R7", "hostReady", 16'(hostReady),
          16'(phQ.size() == 0 && !mRun && !(dmaEnable && !mEnPrev)));
      chk("R8", "memRdEn", 16'(memRdEn), 16'(memEn));
      if (memEn) chk("R8", "memAddr", 16'(memAddr), 16'(mAddr));
      chk("R9", "dmaDone", 16'(dmaDone), 16'(mDone));
      chk("R6", "readValid", 16'(readValid), 16'(expRv));
      if (expRv) chk("R6", "readData", readData, expRd);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic waitIdle();
    tick(1);
    while (phQ.size() != 0 || mRun) tick(1);
  endtask

  task automatic hostSend(input bit w, input bit isData, input bit cs, input logic [15:0] d);
    hostValid = 1; hostWrite = w; hostIsData = isData; hostCs = cs; hostWdata = d;
    do @(negedge clk); while (!hostTook);
    #1 hostValid = 0;
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 0;
    wSetup = 0; wStrobe = 0; wHold = 0; rSetup = 0; rStrobe = 0; rHold = 0; turnAround = 0;
    polRs = 0; polStrobe = 0; polCs0 = 0; polCs1 = 0;
    hostValid = 0; hostWrite = 0; hostIsData = 0; hostCs = 0; hostWdata = 0;
    dmaEnable = 0; dmaCs = 0; dmaBase = 0; dmaCeiling = 0; doneClear = 0;
    busIn = 0; memRdata = 0;
    tick(3);
    // R1 reset state, all polarity bits 0
    chk("R1", "busy",      16'(busy),      16'd0);
    chk("R1", "hostReady", 16'(hostReady), 16'd1);
    chk("R1", "cs0Line",   16'(cs0Line),   16'd1);
    chk("R1", "cs1Line",   16'(cs1Line),   16'd1);
    chk("R1", "rsLine",    16'(rsLine),    16'd1);
    chk("R1", "wrLine",    16'(wrLine),    16'd1);
    chk("R1", "rdLine",    16'(rdLine),    16'd1);
    chk("R1", "busOe",     16'(busOe),     16'd0);
    chk("R1", "memRdEn",   16'(memRdEn),   16'd0);
    chk("R1", "dmaDone",   16'(dmaDone),   16'd0);
    chk("R1", "readValid", 16'(readValid), 16'd0);
    rstN = 1;
    cmpOn = 1;

    // R2 R3 minimal timing, upper byte dropped
    hostSend(1, 1, 0, 16'hA5C3);
    waitIdle();

    // R2 R4 R7 longer phases, back-to-back stalled requests
    wSetup = 2; wStrobe = 3; wHold = 1; turnAround = 2;
    hostSend(1, 0, 1, 16'h7E21);
    hostSend(1, 1, 1, 16'hFF96);
    hostSend(1, 1, 0, 16'h1234);
    waitIdle();

    // R6 reads with their own timing
    rSetup = 1; rStrobe = 2; rHold = 1; busIn = 8'h5A;
    hostSend(0, 1, 0, 16'h0000);
    waitIdle();
    rSetup = 0; rHold = 0; turnAround = 0; busIn = 8'hC7;
    hostSend(0, 0, 1, 16'hFFFF);
    waitIdle();

    // R5 active-high lines
    polRs = 1; polStrobe = 1; polCs0 = 1; polCs1 = 1;
    wSetup = 1; wStrobe = 0; wHold = 2; turnAround = 1;
    hostSend(1, 1, 1, 16'hBEEF);
    hostSend(0, 0, 0, 16'h0000);
    waitIdle();
    polRs = 0; polCs1 = 0;

    // R8 R9 R10 DMA run starting together with a host request, clear held high
    wSetup = 1; wStrobe = 1; wHold = 0; turnAround = 1;
    dmaBase = 6'd3; dmaCeiling = 6'd6; dmaCs = 1; doneClear = 1;
    dmaEnable = 1;
    hostValid = 1; hostWrite = 1; hostIsData = 0; hostCs = 0; hostWdata = 16'h0042;
    #0.5;
    chk("R10", "hostReady at DMA start", 16'(hostReady), 16'd0);
    do @(negedge clk); while (!hostTook);
    #1 hostValid = 0;
    waitIdle();
    doneClear = 0;

    // R8 R9 single-word run, flag sticky until cleared
    dmaEnable = 0;
    tick(2);
    wSetup = 0; wStrobe = 0; wHold = 0; turnAround = 0;
    dmaBase = 6'd9; dmaCeiling = 6'd9; dmaCs = 0;
    dmaEnable = 1;
    waitIdle();
    tick(4);
    chk("R9", "dmaDone sticky", 16'(dmaDone), 16'd1);
    doneClear = 1;
    tick(1);
    doneClear = 0;
    tick(3);

    cmpOn = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule